// File: doc/BRIEF.md
# Isochronous Receive Context Filter

This block decides, header by header, whether an incoming isochronous packet belongs to one receive DMA context. Software configures it through a single 32-bit match register. That register selects which tag values are welcome, the channel to listen on, a sync value for wait-for-sync descriptors, an optional prefix rule for tag 01b, and a 15-bit cycle time at which a cycle-gated context should start.

Each header is presented with a one-cycle valid strobe. The block answers one clock later with an accept flag and a sync-hit flag. Independently, it watches the bus cycle timer. When cycle matching is enabled, it emits a single start pulse on the first cycle whose time equals the programmed value.

Top module: `iso_rx_filter`

## Requirements
- R1: A synchronous reset clears the match register to zero and drives all three outputs low. With the register at zero, no packet is accepted.
- R2: A register write stores the data except bit 27 and bit 7, which always read back as zero. Reads are combinational from the stored register.
- R3: Bits 31, 30, 29 and 28 enable acceptance of tag values 3, 2, 1 and 0 respectively. A packet whose tag enable bit is clear is rejected.
- R4: A packet is accepted only if its 6-bit channel equals register bits 5:0.
- R5: When bit 6 is set, a tag-1 packet is rejected unless bits 3:2 of its sync field are 00b. Tags 0, 2 and 3 are never affected by bit 6.
- R6: The accept and sync-hit flags are registered. Each is high only in the clock after a cycle with header-valid high, and low in every other cycle.
- R7: Sync-hit is high only for an accepted packet with wait-for-sync requested whose 4-bit sync field equals register bits 11:8. Without wait-for-sync it stays low.
- R8: The cycle compare value is register bits 26:12. Bits 26:25 are compared with the two low bits of the timer's seconds field, and bits 24:12 with the 13-bit cycle count. Higher seconds bits are ignored.
- R9: With the cycle-match enable high, the start output pulses for exactly one clock, one clock after the first matching cycle. No further pulse comes until the enable has been low and is raised again. With the enable low, no pulse comes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Write strobe for the match register |
| reg_wr_data | input | 32 | Write data for the match register |
| reg_rd_data | output | 32 | Current match register contents |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_tag | input | 2 | Packet tag field |
| hdr_chan | input | 6 | Packet channel number |
| hdr_sync | input | 4 | Packet sync field |
| wait_sync | input | 1 | Descriptor requests wait-for-sync |
| cyc_seconds | input | 7 | Cycle timer seconds field |
| cyc_count | input | 13 | Cycle timer cycle count |
| cyc_match_en | input | 1 | Cycle-match enable control |
| pkt_accept | output | 1 | Packet belongs to this context (one clock after valid) |
| sync_hit | output | 1 | Accepted packet matched the sync value |
| ctx_start | output | 1 | One-clock start pulse on cycle match |

## Verification
A corrupted match register shows up at the ports within one clock. Either the readback differs, or the accept or sync-hit flag is wrong on the very next header. The sweep covers every tag mask, both settings of the prefix rule, every tag and sync value, and a matching and a mismatching channel, so a single wrong bit cannot go unseen. A start tracker that fails to arm shows as a missing pulse. One that fails to disarm shows as a second pulse when the same cycle time recurs. Either fault is visible one clock after the matching cycle.

// File: rtl/iso_rx_filter.sv
module iso_rx_filter (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        hdr_valid,
  input  logic [1:0]  hdr_tag,
  input  logic [5:0]  hdr_chan,
  input  logic [3:0]  hdr_sync,
  input  logic        wait_sync,
  input  logic [6:0]  cyc_seconds,
  input  logic [12:0] cyc_count,
  input  logic        cyc_match_en,
  output logic        pkt_accept,
  output logic        sync_hit,
  output logic        ctx_start
);

  localparam logic [31:0] WR_MASK = 32'hF7FF_FF7F;

  logic [31:0] ctx_reg;
  logic        start_done;

  wire [3:0]  tag_en    = ctx_reg[31:28];
  wire [14:0] cyc_val   = ctx_reg[26:12];
  wire [3:0]  sync_val  = ctx_reg[11:8];
  wire        tag1_filt = ctx_reg[6];
  wire [5:0]  chan_val  = ctx_reg[5:0];

  wire prefix_block = tag1_filt && (hdr_tag == 2'b01) && (hdr_sync[3:2] != 2'b00);
  wire accept_now   = hdr_valid && (hdr_chan == chan_val) && tag_en[hdr_tag] && !prefix_block;
  wire hit_now      = accept_now && wait_sync && (hdr_sync == sync_val);
  wire cyc_hit      = ({cyc_seconds[1:0], cyc_count} == cyc_val);
  wire fire         = cyc_match_en && !start_done && cyc_hit;

  assign reg_rd_data = ctx_reg;

  always_ff @(posedge clk) begin
    if (rst) ctx_reg <= '0;
    else if (reg_wr_en) ctx_reg <= reg_wr_data & WR_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_accept <= 1'b0;
      sync_hit   <= 1'b0;
    end else begin
      pkt_accept <= accept_now;
      sync_hit   <= hit_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_start  <= 1'b0;
      start_done <= 1'b0;
    end else begin
      ctx_start  <= fire;
      start_done <= cyc_match_en && (start_done || fire);
    end
  end

  a_r6_flags_follow_valid: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hdr_valid)) |-> (!pkt_accept && !sync_hit));

  a_r7_hit_needs_accept: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> pkt_accept);

  a_r7_hit_needs_wait: assert property (@(posedge clk) disable iff (rst)
    (sync_hit && !$past(rst)) |-> $past(wait_sync));

  a_r9_start_single: assert property (@(posedge clk) disable iff (rst)
    ctx_start |=> !ctx_start);

  a_r9_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (ctx_start && !$past(rst)) |-> $past(cyc_match_en));

endmodule

// File: tb/iso_rx_filter_tb.sv
module iso_rx_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        hdr_valid = 1'b0;
  logic [1:0]  hdr_tag = '0;
  logic [5:0]  hdr_chan = '0;
  logic [3:0]  hdr_sync = '0;
  logic        wait_sync = 1'b0;
  logic [6:0]  cyc_seconds = '0;
  logic [12:0] cyc_count = '0;
  logic        cyc_match_en = 1'b0;
  logic        pkt_accept, sync_hit, ctx_start;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  iso_rx_filter u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .hdr_valid(hdr_valid), .hdr_tag(hdr_tag),
    .hdr_chan(hdr_chan), .hdr_sync(hdr_sync), .wait_sync(wait_sync),
    .cyc_seconds(cyc_seconds), .cyc_count(cyc_count), .cyc_match_en(cyc_match_en),
    .pkt_accept(pkt_accept), .sync_hit(sync_hit), .ctx_start(ctx_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pkt(input logic [1:0] t, input logic [5:0] c, input logic [3:0] s,
                     input logic ws, input logic ea, input logic eh, input string req);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_tag = t; hdr_chan = c; hdr_sync = s; wait_sync = ws;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk({req, " accept"}, {31'b0, pkt_accept}, {31'b0, ea});
    chk({req, " sync_hit"}, {31'b0, sync_hit}, {31'b0, eh});
  endtask

  task automatic cyc(input logic [6:0] sec, input logic [12:0] cnt, input logic en,
                     input logic exp, input string req);
    @(negedge clk);
    cyc_seconds = sec; cyc_count = cnt; cyc_match_en = en;
    @(negedge clk);
    chk(req, {31'b0, ctx_start}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reg", reg_rd_data, 32'h0);
    chk("R1 accept", {31'b0, pkt_accept}, 32'h0);
    chk("R1 start", {31'b0, ctx_start}, 32'h0);
    pkt(2'd0, 6'd0, 4'd0, 1'b1, 1'b0, 1'b0, "R1 zero reg");

    // R2: reserved bits read zero
    wr(32'hFFFF_FFFF);
    chk("R2 readback", reg_rd_data, 32'hF7FF_FF7F);
    wr(32'h1234_5678);
    chk("R2 readback2", reg_rd_data, 32'h1234_5678 & 32'hF7FF_FF7F);

    // R3 R4 R5 R7: sweep tag masks, prefix rule, tags, sync, channel, wait-for-sync
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 2; f++) begin
        wr({m[3:0], 1'b0, 15'h0, 4'hA, 1'b0, f[0], 6'h2B});
        for (int t = 0; t < 4; t++) begin
          for (int s = 0; s < 16; s++) begin
            for (int ci = 0; ci < 2; ci++) begin
              logic [5:0] c;
              logic ws, ea, eh;
              c  = (ci == 0) ? 6'h2B : 6'h2A;
              ws = ((s >> 1) ^ t ^ ci) & 1;
              ea = (ci == 0) && (((m >> t) & 1) == 1) && !(f == 1 && t == 1 && s >= 4);
              eh = ea && ws && (s == 10);
              pkt(t[1:0], c, s[3:0], ws, ea, eh, "R3 R4 R5 R7");
            end
          end
        end
      end
    end

    // R6: flags low in the cycle after an idle cycle
    @(negedge clk);
    chk("R6 idle accept", {31'b0, pkt_accept}, 32'h0);
    chk("R6 idle hit", {31'b0, sync_hit}, 32'h0);

    // R8 R9: cycle match start, compare value {2'b10, 13'd100}
    wr({4'h0, 1'b0, 2'b10, 13'd100, 12'h0});
    cyc(7'd2, 13'd100, 1'b0, 1'b0, "R9 disabled no start");
    cyc(7'd2, 13'd99,  1'b1, 1'b0, "R8 no match");
    cyc(7'd2, 13'd100, 1'b1, 1'b1, "R9 first match pulse");
    cyc(7'd2, 13'd101, 1'b1, 1'b0, "R9 pulse one clock");
    cyc(7'd2, 13'd100, 1'b1, 1'b0, "R9 once per arming");
    cyc(7'd2, 13'd50,  1'b0, 1'b0, "R9 disarm");
    cyc(7'd1, 13'd100, 1'b1, 1'b0, "R8 seconds mismatch");
    cyc(7'd5, 13'd100, 1'b1, 1'b0, "R8 seconds mismatch 2");
    cyc(7'd6, 13'd100, 1'b1, 1'b1, "R8 upper seconds ignored, R9 rearm");
    cyc(7'd6, 13'd100, 1'b1, 1'b0, "R9 no repeat");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule